// File: doc/BRIEF.md
# Shared Converter Data-Bus Controller

This block arbitrates a single 10-bit bidirectional sample bus between a digital baseband and a pair of converters. In the transmit direction the baseband places one DAC sample per clock on the bus. In the receive direction the block drives ADC samples onto the same wires back toward the baseband. A direction input turns the bus around. A separate transmit-enable input decides whether the captured samples are actually launched onto the line. Both sample directions are timed on the falling clock edge.

The block also decodes the power-down strobes for the receive section, the transmit section and the DAC. These strobes come from the mode inputs, four configuration bits supplied by an external control-register block, a receiver-shutdown input and a standby input. The pad is modelled as a split bus (input value, output value, output enable), and the analog paths are modelled as plain sample ports. Samples are unsigned binary.

Top module: `conv_bus_ctrl`

## Requirements
- R1: While `rst_n` is low, `bus_oe`, `line_oe`, `bus_out` and `dac_data` are all 0, and the bus is left undriven.
- R2: `bus_oe` is 0 in any cycle where `dir_in` is 1. It drops in the same cycle that `dir_in` rises, with no clock edge needed.
- R3: With `dir_in` = 0 and `rx_pd` = 0 at a falling edge, `bus_oe` is 1 after that edge for as long as `dir_in` stays 0. `bus_out` then equals the `adc_sample` value captured at the most recent falling edge.
- R4: At each falling edge where `dir_in` = 1 and `dac_pd` = 0, `dac_data` takes the value of `bus_in`. At a falling edge with `dir_in` = 0 and `dac_pd` = 0, `dac_data` holds its value.
- R5: After each falling edge, `line_oe` is 1 exactly when `dir_in`, `tx_en` and `!tx_pd` were all 1 at that edge. Otherwise the line output is three-stated (`line_oe` = 0).
- R6: `rx_pd` = `standby | cfg_sleep | rx_shut | (cfg_rxoff_tx & dir_in & tx_en)`. A high `rx_shut` near the end of a burst therefore idles the receiver while transmitting.
- R7: `tx_pd` = `standby | cfg_sleep | (cfg_txoff_rx & !(dir_in & tx_en))`.
- R8: `dac_pd` = `standby | cfg_sleep | (cfg_dacoff_rx & !dir_in)`. At a falling edge with `dac_pd` = 1, `dac_data` is cleared to 0.
- R9: With `standby` or `cfg_sleep` high, all three power-down outputs are 1. After the next falling edge, `line_oe`, `bus_oe` and `dac_data` are all 0.
- R10: At a falling edge with `rx_pd` = 1, the captured ADC value becomes 0, and `bus_oe` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; samples move on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_in | input | 1 | Bus direction: 1 = baseband to DAC, 0 = ADC to baseband |
| tx_en | input | 1 | Transmit enable for the line output |
| rx_shut | input | 1 | Receiver shutdown request |
| standby | input | 1 | Whole-block standby |
| cfg_rxoff_tx | input | 1 | Config: idle the receiver while transmitting (register default 1) |
| cfg_txoff_rx | input | 1 | Config: idle the transmitter while not transmitting (register default 1) |
| cfg_dacoff_rx | input | 1 | Config: idle the DAC in receive direction (register default 0) |
| cfg_sleep | input | 1 | Config: power down everything (register default 0) |
| bus_in | input | DW | Value seen on the shared bus pads |
| bus_out | output | DW | Value driven onto the shared bus |
| bus_oe | output | 1 | Pad output enable for the shared bus |
| adc_sample | input | DW | Sample from the ADC |
| dac_data | output | DW | Registered sample toward the DAC |
| line_oe | output | 1 | Line output enable (0 = three-stated) |
| rx_pd | output | 1 | Receive section power-down |
| tx_pd | output | 1 | Transmit section power-down |
| dac_pd | output | 1 | DAC power-down |

## Verification
The assertions assume that every input changes only between falling edges. They also assume that reset is held low for at least five clock cycles and released away from a falling edge. The stimulus meets both conditions: inputs are driven one time unit after each rising edge, and the reset pulse lasts eight cycles, started and ended just after a rising edge. Within those limits the stimulus covers directed bursts, turnarounds in both directions, standby, sleep and the configuration bits, followed by randomized mode traffic that holds `dir_in` for runs of several cycles.

// File: rtl/conv_bus_ctrl.sv
module conv_bus_ctrl #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_in,
  input  logic          tx_en,
  input  logic          rx_shut,
  input  logic          standby,
  input  logic          cfg_rxoff_tx,
  input  logic          cfg_txoff_rx,
  input  logic          cfg_dacoff_rx,
  input  logic          cfg_sleep,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  input  logic [DW-1:0] adc_sample,
  output logic [DW-1:0] dac_data,
  output logic          line_oe,
  output logic          rx_pd,
  output logic          tx_pd,
  output logic          dac_pd
);

  localparam logic [DW-1:0] ZERO = '0;

  logic          tx_active;
  logic          chip_off;
  logic          drive_q;
  logic          line_q;
  logic [DW-1:0] adc_q;
  logic [DW-1:0] dac_q;

  assign tx_active = dir_in & tx_en;
  assign chip_off  = standby | cfg_sleep;
  assign rx_pd     = chip_off | rx_shut | (cfg_rxoff_tx & tx_active);
  assign tx_pd     = chip_off | (cfg_txoff_rx & ~tx_active);
  assign dac_pd    = chip_off | (cfg_dacoff_rx & ~dir_in);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adc_q   <= ZERO;
      drive_q <= 1'b0;
    end else begin
      adc_q   <= rx_pd ? ZERO : adc_sample;
      drive_q <= ~dir_in & ~rx_pd;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q  <= ZERO;
      line_q <= 1'b0;
    end else begin
      if (dac_pd)      dac_q <= ZERO;
      else if (dir_in) dac_q <= bus_in;
      line_q <= tx_active & ~tx_pd;
    end
  end

  assign bus_oe   = drive_q & ~dir_in;
  assign bus_out  = adc_q;
  assign dac_data = dac_q;
  assign line_oe  = line_q;

  assert_reset_quiet_R1: assert property (@(negedge clk)
    !rst_n |-> (!bus_oe && !line_oe && bus_out == ZERO && dac_data == ZERO));

  assert_turnaround_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_in && $past(!dir_in)) |-> !bus_oe);

  assert_rx_drive_R3: assert property (@(negedge clk) disable iff (!rst_n)
    (!dir_in && !rx_pd) |=> (dir_in || bus_oe));

  assert_dac_capture_R4: assert property (@(negedge clk) disable iff (!rst_n)
    (dir_in && !dac_pd) |=> (dac_data == $past(bus_in)));

  assert_dac_hold_R4: assert property (@(negedge clk) disable iff (!rst_n)
    (!dir_in && !dac_pd) |=> $stable(dac_data));

  assert_line_on_R5: assert property (@(negedge clk) disable iff (!rst_n)
    (dir_in && tx_en && !tx_pd) |=> line_oe);

  assert_line_off_R5: assert property (@(negedge clk) disable iff (!rst_n)
    !(dir_in && tx_en) |=> !line_oe);

  assert_rx_shut_R6: assert property (@(negedge clk) disable iff (!rst_n)
    rx_shut |-> rx_pd);

  assert_sleep_all_R9: assert property (@(negedge clk) disable iff (!rst_n)
    (standby || cfg_sleep) |=> (!line_oe && !bus_oe && dac_data == ZERO));

  assert_rx_zero_R10: assert property (@(negedge clk) disable iff (!rst_n)
    rx_pd |=> (bus_out == ZERO && !bus_oe));

endmodule

// File: tb/test_conv_bus_ctrl.sv
module test_conv_bus_ctrl;
  localparam int DW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_in = 0, tx_en = 0, rx_shut = 0, standby = 0;
  logic cfg_rxoff_tx = 1, cfg_txoff_rx = 1, cfg_dacoff_rx = 0, cfg_sleep = 0;
  logic [DW-1:0] bus_in = '0, adc_sample = '0;
  logic [DW-1:0] bus_out, dac_data;
  logic bus_oe, line_oe, rx_pd, tx_pd, dac_pd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_dac = 0, m_adc = 0;
  bit m_drive = 0, m_line = 0;

  always #2 clk = ~clk;

  conv_bus_ctrl #(.DW(DW)) i_conv_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .dir_in(dir_in), .tx_en(tx_en), .rx_shut(rx_shut),
    .standby(standby), .cfg_rxoff_tx(cfg_rxoff_tx), .cfg_txoff_rx(cfg_txoff_rx),
    .cfg_dacoff_rx(cfg_dacoff_rx), .cfg_sleep(cfg_sleep), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .adc_sample(adc_sample), .dac_data(dac_data),
    .line_oe(line_oe), .rx_pd(rx_pd), .tx_pd(tx_pd), .dac_pd(dac_pd)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit e_rx_pd();
    return standby | cfg_sleep | rx_shut | (cfg_rxoff_tx & dir_in & tx_en);
  endfunction
  function automatic bit e_tx_pd();
    return standby | cfg_sleep | (cfg_txoff_rx & !(dir_in & tx_en));
  endfunction
  function automatic bit e_dac_pd();
    return standby | cfg_sleep | (cfg_dacoff_rx & !dir_in);
  endfunction

  // Reference model: one step per falling edge, from the inputs only.
  always @(negedge clk) begin
    if (!rst_n) begin
      m_dac = 0; m_adc = 0; m_drive = 0; m_line = 0;
    end else begin
      if (e_dac_pd()) m_dac = 0;
      else if (dir_in) m_dac = int'(bus_in);
      m_adc   = e_rx_pd() ? 0 : int'(adc_sample);
      m_drive = !dir_in && !e_rx_pd();
      m_line  = dir_in && tx_en && !e_tx_pd();
    end
  end

  // Compare one time unit after every falling edge.
  always @(negedge clk) begin
    #1;
    if (!done) begin
      if (!rst_n) begin
        chk(!bus_oe && !line_oe && bus_out == 0 && dac_data == 0, "R1", "reset outputs",
            {bus_oe, line_oe, |bus_out, |dac_data}, 0);
      end else begin
        chk(bus_oe == (m_drive && !dir_in), dir_in ? "R2" : "R3", "bus_oe", bus_oe, m_drive && !dir_in);
        chk(int'(bus_out) == m_adc, (standby || cfg_sleep || rx_pd) ? "R10" : "R3", "bus_out", bus_out, m_adc);
        chk(int'(dac_data) == m_dac, dac_pd ? "R8" : "R4", "dac_data", dac_data, m_dac);
        chk(line_oe == m_line, (standby || cfg_sleep) ? "R9" : "R5", "line_oe", line_oe, m_line);
        chk(rx_pd == e_rx_pd(), "R6", "rx_pd", rx_pd, e_rx_pd());
        chk(tx_pd == e_tx_pd(), "R7", "tx_pd", tx_pd, e_tx_pd());
        chk(dac_pd == e_dac_pd(), "R8", "dac_pd", dac_pd, e_dac_pd());
      end
    end
  end

  task automatic step(input bit d, input bit te, input bit rs, input bit sb,
                      input bit c0, input bit c1, input bit c2, input bit c3,
                      input int bi, input int ai);
    @(posedge clk);
    #1;
    dir_in = d; tx_en = te; rx_shut = rs; standby = sb;
    cfg_rxoff_tx = c0; cfg_txoff_rx = c1; cfg_dacoff_rx = c2; cfg_sleep = c3;
    bus_in = DW'(bi); adc_sample = DW'(ai);
    #0.5;
    if (d) chk(!bus_oe, "R2", "bus_oe immediately after direction rise", bus_oe, 0);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (8) @(posedge clk);
    #1 rst_n = 1'b1;
    // R3: receive with an ADC ramp
    for (int i = 0; i < 12; i++) step(0, 0, 0, 0, 1, 1, 0, 0, 0, 100 + i * 37);
    // R4 R5 R6: transmit burst, receiver idled while transmitting
    for (int i = 0; i < 12; i++) step(1, 1, 0, 0, 1, 1, 0, 0, 1023 - i * 51, 5);
    // R6: shutdown request near end of burst
    step(1, 1, 1, 0, 0, 1, 0, 0, 77, 9);
    step(1, 1, 1, 0, 0, 1, 0, 0, 78, 9);
    // R2 R3: turnarounds back and forth
    for (int i = 0; i < 10; i++) step(i % 2, 1, 0, 0, 0, 0, 0, 0, 300 + i, 600 + i);
    // R5: direction high with transmit disabled leaves line three-stated; R4 still captures
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 1, 1, 0, 0, 512 + i, 1);
    // R4 hold and R8 DAC idle in receive
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 1, 0, 0, 1, 200 + i);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 1, 1, 0, 1, 210 + i);
    // R9: standby, then sleep bit, then wake
    for (int i = 0; i < 4; i++) step(1, 1, 0, 1, 1, 1, 0, 0, 999, 888);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 0, 1, 999, 888);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 1, 0, 0, 4, 1023);
    // R10: receiver shutdown in receive direction
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 1, 1, 0, 0, 4, 700);
    // Random traffic with runs of held direction
    for (int r = 0; r < 300; r++) begin
      bit d = 1'($urandom_range(0, 1));
      bit te = 1'($urandom_range(0, 3) != 0);
      bit c0 = 1'($urandom_range(0, 1));
      bit c1 = 1'($urandom_range(0, 1));
      bit c2 = 1'($urandom_range(0, 1));
      int run = $urandom_range(1, 6);
      for (int k = 0; k < run; k++)
        step(d, te, 1'($urandom_range(0, 7) == 0), 1'($urandom_range(0, 15) == 0),
             c0, c1, c2, 1'($urandom_range(0, 31) == 0),
             int'($urandom_range(0, 1023)), int'($urandom_range(0, 1023)));
    end
    // R1: reset again mid-traffic
    @(posedge clk);
    #1 rst_n = 1'b0;
    repeat (8) @(posedge clk);
    #1 rst_n = 1'b1;
    step(0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
    @(negedge clk);
    #2;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule